// File: doc/BRIEF.md
# Deflection Routing Switch Allocator

This block decides, once per clock, where every flit that arrives at a bufferless mesh router goes. The router has four network inputs and four network outputs (north, east, south, west) plus a local port. No flit is ever held or dropped. The incoming flits are ordered oldest first. In that order, each flit takes a free output that brings it closer to its destination. When no such output is free, it takes any other free output and is deflected. A flit that has reached this node leaves through the local eject port.

The local node offers one flit for injection. That flit is accepted only when an input slot is empty and the router still has an unused on-mesh output for it. An accepted flit takes part in the allocation like any other flit, with age zero.

The allocation logic is combinational. Its result is registered together with the switched flits, so each flit appears on its output one clock after it arrives. Every outgoing network flit carries its age stamp incremented by one, saturating at the top value. Each output also reports the slot its flit came from, which acts as the crossbar select.

Top module: `defl_alloc`

## Requirements
- R1: Every valid input flit, and an accepted injected flit, appears on the clock after it arrives on exactly one network output or on the eject port. No two outputs carry the same source.
- R2: Flits are ranked by age, and a larger age means older. Between equal ages, the lower slot index ranks higher. An injected flit has age 0 and occupies the lowest-numbered empty input slot.
- R3: Port indices are N=0, E=1, S=2, W=3. East is productive when the destination x is greater than here_x, west when it is smaller. South is productive when the destination y is greater than here_y, north when it is smaller. Among free productive ports, the x port is taken before the y port.
- R4: Ports are handed out greedily in rank order. A flit with no free productive port takes the lowest-index free on-mesh port.
- R5: A flit whose destination equals (here_x, here_y) is ejected, but only one flit per clock is ejected: the highest-ranked such flit. Any other such flit is deflected as in R4.
- R6: An output that leads off the mesh edge is never valid. North is off the mesh when here_y=0, south when here_y=MESH_Y-1, west when here_x=0, and east when here_x=MESH_X-1.
- R7: inj_grant is combinational. It is 1 exactly when inj_req is high and fewer input slots are valid than there are on-mesh outputs. The injected flit reports source code 4.
- R8: A network output carries its flit's destination and payload unchanged, with age+1 saturating at 2^AGE_W-1. The eject port carries the flit with its age unchanged.
- R9: Outputs are registered, with one clock of latency. A synchronous reset clears every output valid.
- R10: out_src and ej_src give the input slot (0 to 3) that supplied the flit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| here_x | input | X_W | This router's x coordinate |
| here_y | input | Y_W | This router's y coordinate |
| in_vld | input | 4 | Valid flag per input slot N,E,S,W |
| in_dx | input | 4*X_W | Destination x per slot |
| in_dy | input | 4*Y_W | Destination y per slot |
| in_age | input | 4*AGE_W | Age stamp per slot |
| in_data | input | 4*DATA_W | Payload per slot |
| inj_req | input | 1 | Local node offers a flit |
| inj_dx | input | X_W | Injected flit destination x |
| inj_dy | input | Y_W | Injected flit destination y |
| inj_data | input | DATA_W | Injected flit payload |
| inj_grant | output | 1 | Offered flit is accepted this clock |
| out_vld | output | 4 | Valid flag per network output |
| out_src | output | 4*3 | Source slot per output (4 = injection) |
| out_dx | output | 4*X_W | Destination x per output |
| out_dy | output | 4*Y_W | Destination y per output |
| out_age | output | 4*AGE_W | Incremented age per output |
| out_data | output | 4*DATA_W | Payload per output |
| ej_vld | output | 1 | Flit ejected to the local node |
| ej_src | output | 3 | Source slot of the ejected flit |
| ej_dx | output | X_W | Ejected flit destination x |
| ej_dy | output | Y_W | Ejected flit destination y |
| ej_age | output | AGE_W | Ejected flit age |
| ej_data | output | DATA_W | Ejected flit payload |

## Verification
The bench drives each scenario for one clock and reads the registered outputs on the next clock, so any fault in the allocation shows up one cycle after its cause. A wrong rank order shows as an older flit deflected while a younger flit gets its productive port. A stale free mask shows as a lost flit or as two outputs reporting the same source, and a bad edge mask shows as a valid flag on an off-mesh output. Injection faults appear on the same cycle on inj_grant, or one cycle later as a missing source code 4.

// File: rtl/defl_pkg.sv
package defl_pkg;
  localparam int NSLOT = 4;
  localparam int PN = 0;
  localparam int PE = 1;
  localparam int PS = 2;
  localparam int PW = 3;
  localparam logic [2:0] SRC_INJ = 3'd4;

  function automatic logic [2:0] ones4(input logic [3:0] v);
    return {2'b00, v[0]} + {2'b00, v[1]} + {2'b00, v[2]} + {2'b00, v[3]};
  endfunction
endpackage

// File: rtl/defl_route.sv
module defl_route #(
  parameter int X_W = 2,
  parameter int Y_W = 2
) (
  input  logic [X_W-1:0] here_x,
  input  logic [Y_W-1:0] here_y,
  input  logic [X_W-1:0] dest_x,
  input  logic [Y_W-1:0] dest_y,
  output logic           home,
  output logic [3:0]     want_x,
  output logic [3:0]     want_y
);
  import defl_pkg::*;

  always_comb begin
    want_x = '0;
    want_y = '0;
    if (dest_x > here_x)      want_x[PE] = 1'b1;
    else if (dest_x < here_x) want_x[PW] = 1'b1;
    if (dest_y > here_y)      want_y[PS] = 1'b1;
    else if (dest_y < here_y) want_y[PN] = 1'b1;
    home = (dest_x == here_x) && (dest_y == here_y);
  end
endmodule

// File: rtl/defl_rank.sv
module defl_rank #(
  parameter int AGE_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [3:0]            vld,
  input  logic [3:0][AGE_W-1:0] age,
  output logic [3:0][1:0]       ord_slot,
  output logic [3:0]            ord_vld
);
  import defl_pkg::*;

  logic [3:0][2:0] rnk;

  always_comb begin
    for (int i = 0; i < NSLOT; i++) begin
      rnk[i] = 3'd0;
      for (int j = 0; j < NSLOT; j++) begin
        if (j != i && vld[j] &&
            ((age[j] > age[i]) || ((age[j] == age[i]) && (j < i))))
          rnk[i] = rnk[i] + 3'd1;
      end
    end
    ord_vld  = '0;
    ord_slot = '0;
    for (int r = 0; r < NSLOT; r++) begin
      for (int i = 0; i < NSLOT; i++) begin
        if (vld[i] && (rnk[i] == 3'(r))) begin
          ord_vld[r]  = 1'b1;
          ord_slot[r] = 2'(i);
        end
      end
    end
  end

  // R2
  ord_dense_chk: assert property (@(posedge clk) disable iff (rst)
    (ones4(ord_vld) == ones4(vld)) && (((ord_vld + 4'd1) & ord_vld) == 4'd0));
endmodule

// File: rtl/defl_pick.sv
module defl_pick (
  input  logic            clk,
  input  logic            rst,
  input  logic [3:0]      live,
  input  logic [3:0][1:0] ord_slot,
  input  logic [3:0]      ord_vld,
  input  logic [3:0][3:0] want_x,
  input  logic [3:0][3:0] want_y,
  input  logic [3:0]      home,
  output logic [3:0]      port_vld,
  output logic [3:0][1:0] port_slot,
  output logic            ej_vld,
  output logic [1:0]      ej_slot
);
  import defl_pkg::*;

  logic [3:0] free;
  logic [3:0] take;
  logic [1:0] s;

  always_comb begin
    free      = live;
    port_vld  = '0;
    port_slot = '0;
    ej_vld    = 1'b0;
    ej_slot   = '0;
    take      = '0;
    s         = '0;
    for (int r = 0; r < NSLOT; r++) begin
      if (ord_vld[r]) begin
        s    = ord_slot[r];
        take = '0;
        if (home[s] && !ej_vld) begin
          ej_vld  = 1'b1;
          ej_slot = s;
        end else if ((want_x[s] & free) != 4'd0) begin
          take = want_x[s] & free;
        end else if ((want_y[s] & free) != 4'd0) begin
          take = want_y[s] & free;
        end else begin
          take = free & (~free + 4'd1);
        end
        for (int p = 0; p < NSLOT; p++) begin
          if (take[p]) begin
            port_vld[p]  = 1'b1;
            port_slot[p] = s;
          end
        end
        free = free & ~take;
      end
    end
  end

  // R1
  all_placed_chk: assert property (@(posedge clk) disable iff (rst)
    (ones4(port_vld) + {2'b00, ej_vld}) == ones4(ord_vld));

  // R6
  edge_port_chk: assert property (@(posedge clk) disable iff (rst)
    (port_vld & ~live) == 4'd0);
endmodule

// File: rtl/defl_alloc.sv
module defl_alloc #(
  parameter int MESH_X = 4,
  parameter int MESH_Y = 4,
  parameter int X_W    = $clog2(MESH_X),
  parameter int Y_W    = $clog2(MESH_Y),
  parameter int AGE_W  = 4,
  parameter int DATA_W = 128
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [X_W-1:0]         here_x,
  input  logic [Y_W-1:0]         here_y,
  input  logic [3:0]             in_vld,
  input  logic [3:0][X_W-1:0]    in_dx,
  input  logic [3:0][Y_W-1:0]    in_dy,
  input  logic [3:0][AGE_W-1:0]  in_age,
  input  logic [3:0][DATA_W-1:0] in_data,
  input  logic                   inj_req,
  input  logic [X_W-1:0]         inj_dx,
  input  logic [Y_W-1:0]         inj_dy,
  input  logic [DATA_W-1:0]      inj_data,
  output logic                   inj_grant,
  output logic [3:0]             out_vld,
  output logic [3:0][2:0]        out_src,
  output logic [3:0][X_W-1:0]    out_dx,
  output logic [3:0][Y_W-1:0]    out_dy,
  output logic [3:0][AGE_W-1:0]  out_age,
  output logic [3:0][DATA_W-1:0] out_data,
  output logic                   ej_vld,
  output logic [2:0]             ej_src,
  output logic [X_W-1:0]         ej_dx,
  output logic [Y_W-1:0]         ej_dy,
  output logic [AGE_W-1:0]       ej_age,
  output logic [DATA_W-1:0]      ej_data
);
  import defl_pkg::*;

  localparam logic [X_W-1:0]   X_LAST  = X_W'(MESH_X - 1);
  localparam logic [Y_W-1:0]   Y_LAST  = Y_W'(MESH_Y - 1);
  localparam logic [AGE_W-1:0] AGE_TOP = '1;

  logic [3:0] live;
  logic [1:0] inj_slot;

  always_comb begin
    live     = '0;
    live[PN] = (here_y != '0);
    live[PS] = (here_y != Y_LAST);
    live[PW] = (here_x != '0);
    live[PE] = (here_x != X_LAST);
    inj_slot = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (!in_vld[i]) inj_slot = 2'(i);
    end
  end

  assign inj_grant = inj_req && (ones4(in_vld) < ones4(live));

  // merged flit set: inputs plus the accepted injection
  logic [3:0]             m_vld;
  logic [3:0][X_W-1:0]    m_dx;
  logic [3:0][Y_W-1:0]    m_dy;
  logic [3:0][AGE_W-1:0]  m_age;
  logic [3:0][DATA_W-1:0] m_data;

  always_comb begin
    m_vld  = in_vld;
    m_dx   = in_dx;
    m_dy   = in_dy;
    m_age  = in_age;
    m_data = in_data;
    if (inj_grant) begin
      m_vld[inj_slot]  = 1'b1;
      m_dx[inj_slot]   = inj_dx;
      m_dy[inj_slot]   = inj_dy;
      m_age[inj_slot]  = '0;
      m_data[inj_slot] = inj_data;
    end
  end

  logic [3:0]      home;
  logic [3:0][3:0] want_x;
  logic [3:0][3:0] want_y;

  for (genvar g = 0; g < NSLOT; g++) begin : g_route
    defl_route #(.X_W(X_W), .Y_W(Y_W)) u_route (
      .here_x (here_x),
      .here_y (here_y),
      .dest_x (m_dx[g]),
      .dest_y (m_dy[g]),
      .home   (home[g]),
      .want_x (want_x[g]),
      .want_y (want_y[g])
    );
  end

  logic [3:0][1:0] ord_slot;
  logic [3:0]      ord_vld;

  defl_rank #(.AGE_W(AGE_W)) u_rank (
    .clk      (clk),
    .rst      (rst),
    .vld      (m_vld),
    .age      (m_age),
    .ord_slot (ord_slot),
    .ord_vld  (ord_vld)
  );

  logic [3:0]      port_vld;
  logic [3:0][1:0] port_slot;
  logic            pk_ej_vld;
  logic [1:0]      pk_ej_slot;

  defl_pick u_pick (
    .clk       (clk),
    .rst       (rst),
    .live      (live),
    .ord_slot  (ord_slot),
    .ord_vld   (ord_vld),
    .want_x    (want_x),
    .want_y    (want_y),
    .home      (home),
    .port_vld  (port_vld),
    .port_slot (port_slot),
    .ej_vld    (pk_ej_vld),
    .ej_slot   (pk_ej_slot)
  );

  // next-state of the output stage (switch traversal)
  logic [3:0][2:0]       n_src;
  logic [3:0][AGE_W-1:0] n_age;
  logic [2:0]            n_ej_src;

  always_comb begin
    for (int p = 0; p < NSLOT; p++) begin
      n_src[p] = (inj_grant && (port_slot[p] == inj_slot)) ? SRC_INJ : {1'b0, port_slot[p]};
      n_age[p] = (m_age[port_slot[p]] == AGE_TOP) ? AGE_TOP : m_age[port_slot[p]] + 1'b1;
    end
    n_ej_src = (inj_grant && (pk_ej_slot == inj_slot)) ? SRC_INJ : {1'b0, pk_ej_slot};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= '0;
      out_src  <= '0;
      out_dx   <= '0;
      out_dy   <= '0;
      out_age  <= '0;
      out_data <= '0;
      ej_vld   <= 1'b0;
      ej_src   <= '0;
      ej_dx    <= '0;
      ej_dy    <= '0;
      ej_age   <= '0;
      ej_data  <= '0;
    end else begin
      out_vld <= port_vld;
      out_src <= n_src;
      out_age <= n_age;
      for (int p = 0; p < NSLOT; p++) begin
        out_dx[p]   <= m_dx[port_slot[p]];
        out_dy[p]   <= m_dy[port_slot[p]];
        out_data[p] <= m_data[port_slot[p]];
      end
      ej_vld  <= pk_ej_vld;
      ej_src  <= n_ej_src;
      ej_dx   <= m_dx[pk_ej_slot];
      ej_dy   <= m_dy[pk_ej_slot];
      ej_age  <= m_age[pk_ej_slot];
      ej_data <= m_data[pk_ej_slot];
    end
  end

  for (genvar a = 0; a < NSLOT; a++) begin : g_chk
    // R8
    age_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
      out_vld[a] |-> (out_age[a] != '0));
    // R1
    ej_distinct_chk: assert property (@(posedge clk) disable iff (rst)
      (out_vld[a] && ej_vld) |-> (out_src[a] != ej_src));
    for (genvar b = a + 1; b < NSLOT; b++) begin : g_pair
      // R1
      distinct_src_chk: assert property (@(posedge clk) disable iff (rst)
        (out_vld[a] && out_vld[b]) |-> (out_src[a] != out_src[b]));
    end
  end

  // R7
  inj_used_chk: assert property (@(posedge clk) disable iff (rst)
    inj_grant |=> ((ej_vld && ej_src == SRC_INJ) ||
                   (out_vld[0] && out_src[0] == SRC_INJ) ||
                   (out_vld[1] && out_src[1] == SRC_INJ) ||
                   (out_vld[2] && out_src[2] == SRC_INJ) ||
                   (out_vld[3] && out_src[3] == SRC_INJ)));
endmodule

// File: tb/defl_alloc_test.sv
module defl_alloc_test;
  localparam int X_W = 2;
  localparam int Y_W = 2;
  localparam int AGE_W = 4;
  localparam int DATA_W = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [X_W-1:0] here_x;
  logic [Y_W-1:0] here_y;
  logic [3:0] in_vld;
  logic [3:0][X_W-1:0] in_dx;
  logic [3:0][Y_W-1:0] in_dy;
  logic [3:0][AGE_W-1:0] in_age;
  logic [3:0][DATA_W-1:0] in_data;
  logic inj_req;
  logic [X_W-1:0] inj_dx;
  logic [Y_W-1:0] inj_dy;
  logic [DATA_W-1:0] inj_data;
  logic inj_grant;
  logic [3:0] out_vld;
  logic [3:0][2:0] out_src;
  logic [3:0][X_W-1:0] out_dx;
  logic [3:0][Y_W-1:0] out_dy;
  logic [3:0][AGE_W-1:0] out_age;
  logic [3:0][DATA_W-1:0] out_data;
  logic ej_vld;
  logic [2:0] ej_src;
  logic [X_W-1:0] ej_dx;
  logic [Y_W-1:0] ej_dy;
  logic [AGE_W-1:0] ej_age;
  logic [DATA_W-1:0] ej_data;

  defl_alloc uut (
    .clk(clk), .rst(rst), .here_x(here_x), .here_y(here_y),
    .in_vld(in_vld), .in_dx(in_dx), .in_dy(in_dy), .in_age(in_age), .in_data(in_data),
    .inj_req(inj_req), .inj_dx(inj_dx), .inj_dy(inj_dy), .inj_data(inj_data),
    .inj_grant(inj_grant), .out_vld(out_vld), .out_src(out_src), .out_dx(out_dx),
    .out_dy(out_dy), .out_age(out_age), .out_data(out_data), .ej_vld(ej_vld),
    .ej_src(ej_src), .ej_dx(ej_dx), .ej_dy(ej_dy), .ej_age(ej_age), .ej_data(ej_data)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_in();
    in_vld = '0; in_dx = '0; in_dy = '0; in_age = '0; in_data = '0;
    inj_req = 1'b0; inj_dx = '0; inj_dy = '0; inj_data = '0;
  endtask

  task automatic put(input int s, input int dx, input int dy, input int age, input int dat);
    in_vld[s] = 1'b1;
    in_dx[s] = X_W'(dx);
    in_dy[s] = Y_W'(dy);
    in_age[s] = AGE_W'(age);
    in_data[s] = DATA_W'(dat);
  endtask

  // drive at negedge, outputs valid after the next posedge, sampled at following negedge
  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic port_is(input string req, input int p, input int vld, input int src);
    chk(req, out_vld[p], vld);
    if (vld != 0) chk(req, out_src[p], src);
  endtask

  task automatic t_reset();
    chk("R9 reset out_vld", out_vld, 0);
    chk("R9 reset ej_vld", ej_vld, 0);
  endtask

  task automatic t_single();
    here_x = 1; here_y = 1; clear_in();
    put(3, 3, 1, 2, 16'hABCD);
    cycle();
    port_is("R3 single east", 1, 1, 3);
    chk("R10 single only east", out_vld, 4'b0010);
    chk("R8 age inc", out_age[1], 3);
    chk("R8 payload", out_data[1], 16'hABCD);
    chk("R8 dest x", out_dx[1], 3);
    clear_in();
  endtask

  task automatic t_xfirst();
    clear_in();
    put(0, 3, 3, 1, 5);
    cycle();
    chk("R3 x preferred", out_vld, 4'b0010);
    port_is("R3 x preferred src", 1, 1, 0);
    clear_in();
  endtask

  task automatic t_oldest();
    clear_in();
    put(0, 3, 1, 5, 1);
    put(2, 2, 1, 7, 2);
    cycle();
    port_is("R2 oldest gets east", 1, 1, 2);
    port_is("R4 younger deflected north", 0, 1, 0);
    clear_in();
  endtask

  task automatic t_tie();
    clear_in();
    put(1, 1, 0, 4, 1);
    put(3, 1, 0, 4, 2);
    cycle();
    port_is("R2 tie lower slot north", 0, 1, 1);
    port_is("R4 tie loser east", 1, 1, 3);
    clear_in();
  endtask

  task automatic t_eject();
    clear_in();
    put(2, 1, 1, 6, 99);
    cycle();
    chk("R5 eject vld", ej_vld, 1);
    chk("R10 eject src", ej_src, 2);
    chk("R8 eject age kept", ej_age, 6);
    chk("R5 no network out", out_vld, 0);
    clear_in();
  endtask

  task automatic t_two_home();
    clear_in();
    put(0, 1, 1, 1, 1);
    put(3, 1, 1, 6, 2);
    cycle();
    chk("R5 older ejects", ej_src, 3);
    chk("R5 one eject", ej_vld, 1);
    port_is("R5 other deflected north", 0, 1, 0);
    clear_in();
  endtask

  task automatic t_full();
    clear_in();
    put(0, 3, 1, 1, 1);
    put(1, 3, 1, 2, 2);
    put(2, 3, 1, 3, 3);
    put(3, 3, 1, 9, 4);
    inj_req = 1'b1; inj_dx = 0; inj_dy = 0;
    #1;
    chk("R7 no grant when full", inj_grant, 0);
    cycle();
    port_is("R4 full N", 0, 1, 2);
    port_is("R4 full E", 1, 1, 3);
    port_is("R4 full S", 2, 1, 1);
    port_is("R4 full W", 3, 1, 0);
    clear_in();
  endtask

  task automatic t_inject();
    clear_in();
    put(0, 1, 0, 3, 1);
    put(1, 2, 1, 3, 2);
    put(2, 1, 3, 3, 3);
    inj_req = 1'b1; inj_dx = 0; inj_dy = 1; inj_data = 128'h77;
    #1;
    chk("R7 grant with empty slot", inj_grant, 1);
    cycle();
    port_is("R7 inject west src4", 3, 1, 4);
    chk("R8 inject age", out_age[3], 1);
    chk("R8 inject payload", out_data[3], 128'h77);
    port_is("R3 N", 0, 1, 0);
    port_is("R3 E", 1, 1, 1);
    port_is("R3 S", 2, 1, 2);
    clear_in();
  endtask

  task automatic t_corner();
    here_x = 0; here_y = 0; clear_in();
    put(1, 2, 0, 5, 1);
    put(2, 3, 0, 6, 2);
    inj_req = 1'b1; inj_dx = 3; inj_dy = 3;
    #1;
    chk("R7 corner no grant", inj_grant, 0);
    cycle();
    port_is("R6 corner east older", 1, 1, 2);
    port_is("R6 corner deflect south", 2, 1, 1);
    chk("R6 N/W never", out_vld & 4'b1001, 0);
    clear_in();
    put(1, 3, 0, 1, 1);
    inj_req = 1'b1; inj_dx = 0; inj_dy = 3;
    #1;
    chk("R7 corner grant", inj_grant, 1);
    cycle();
    port_is("R7 corner inj south", 2, 1, 4);
    port_is("R2 corner east", 1, 1, 1);
    clear_in();
  endtask

  task automatic t_sat();
    here_x = 1; here_y = 1; clear_in();
    put(0, 3, 1, 15, 1);
    put(2, 1, 3, 14, 2);
    cycle();
    chk("R8 saturate 15", out_age[1], 15);
    chk("R8 14 to 15", out_age[2], 15);
    clear_in();
    cycle();
    chk("R1 idle nothing out", out_vld, 0);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    here_x = 1; here_y = 1;
    clear_in();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_single();
    t_xfirst();
    t_oldest();
    t_tie();
    t_eject();
    t_two_home();
    t_full();
    t_inject();
    t_corner();
    t_sat();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule